// File: doc/BRIEF.md
# Single-Cycle 32-Bit Load/Store Core

This block is a small 32-bit processor that completes every instruction in one clock. It runs a fixed set of nine instructions: five register-to-register operations (add, sub, and, or, slt), a word load, a word store, a branch on register equality and an absolute jump. The block holds the program counter, the next-PC selection, a bank of 32 general registers, the instruction decoder, the ALU and the immediate sign extension.

Instruction and data memories sit outside the block. The core puts the current PC on `imem_addr` and expects the instruction word back on `imem_data` in the same cycle. Loads and stores drive `dmem_addr`, `dmem_wdata` and `dmem_we`, and read data arrives combinationally on `dmem_rdata`. Any opcode or function code outside the supported set writes nothing and simply advances the PC by 4.

The decoder first sorts each instruction into a kind: REG_OP, LOAD, STORE, BRANCH, JUMP or NOP. It then produces the control word for that kind. The only state transition is the PC update at each clock edge, and it takes one of four paths. It reloads the reset value, steps to PC+4, takes the branch target when a BRANCH compares equal, or takes the jump target on JUMP.

Top module: `sc_core`

## Requirements
- R1: A synchronous active-high `rst` loads the PC with 0 at the next rising clock edge. The PC does not change before that edge.
- R2: An instruction that is neither a taken branch nor a jump moves the PC to PC+4.
- R3: Opcode 6'h00 is a register operation laid out as rs[25:21], rt[20:16], rd[15:11], funct[5:0], and its result is written to rd. The funct codes are 6'h20 for add, 6'h22 for rs minus rt, 6'h24 for bitwise and, and 6'h25 for bitwise or.
- R4: funct 6'h2A (set-less-than) writes 1 to rd when rs is below rt as a signed two's-complement value, and writes 0 otherwise.
- R5: Opcode 6'h23 loads a word. It reads from the address rs + sign-extended instr[15:0] and writes the returned data into rt (instr[20:16]).
- R6: Opcode 6'h2B stores a word. It drives `dmem_we` high, puts rs + sign-extended instr[15:0] on `dmem_addr` and puts rt on `dmem_wdata`. `dmem_we` is low for every other instruction.
- R7: Opcode 6'h04 compares rs and rt. When they are equal, the next PC is PC+4 plus the sign-extended instr[15:0] shifted left by 2, and a negative offset branches backwards.
- R8: When the two registers of opcode 6'h04 differ, the next PC is PC+4.
- R9: Opcode 6'h02 sets the next PC to {PC+4[31:28], instr[25:0], 2'b00}.
- R10: Register 0 always reads as zero. A write aimed at it is discarded.
- R11: A register write changes only the addressed destination, and every other register keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the PC |
| imem_addr | output | 32 | Current PC, the address of the instruction being fetched |
| imem_data | input | 32 | Instruction word at `imem_addr` |
| dmem_addr | output | 32 | Data memory byte address (base plus offset) |
| dmem_wdata | output | 32 | Store data (rt value) |
| dmem_we | output | 1 | Data memory write strobe, high only for a store |
| dmem_rdata | input | 32 | Data memory read data for loads |

## Verification
Register contents cannot be seen at the ports, so the hardest thing to observe is a register value, especially one that should not have changed (R10, R11). The stimulus therefore loads operands from data memory, runs the operation and then stores the destination registers back to known locations, so every register result comes out on `dmem_addr` and `dmem_wdata`. Branch and jump targets are read directly from `imem_addr` in the cycle after the control-flow instruction. Each program ends in a branch-to-self, which also exercises the negative branch offset.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;

    localparam int XLEN = 32;

    // primary opcodes
    localparam logic [5:0] OPC_REG   = 6'h00;
    localparam logic [5:0] OPC_LOAD  = 6'h23;
    localparam logic [5:0] OPC_STORE = 6'h2B;
    localparam logic [5:0] OPC_BEQ   = 6'h04;
    localparam logic [5:0] OPC_JUMP  = 6'h02;

    // function codes of register operations
    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [2:0] {
        KIND_REG_OP,
        KIND_LOAD,
        KIND_STORE,
        KIND_BRANCH,
        KIND_JUMP,
        KIND_NOP
    } instr_kind_e;

    typedef enum logic [2:0] {
        ALU_AND,
        ALU_OR,
        ALU_ADD,
        ALU_SUB,
        ALU_SLT
    } alu_op_e;

    typedef struct packed {
        logic    reg_we;   // write the register bank
        logic    dst_rd;   // destination is rd (else rt)
        logic    src_imm;  // ALU B operand is the immediate
        logic    wb_mem;   // write-back data from memory
        logic    mem_we;   // store strobe
        logic    is_beq;   // equality branch
        logic    is_jmp;   // absolute jump
        alu_op_e alu_op;
    } ctrl_t;

endpackage

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int NREGS = 32,
    parameter int W     = 32
) (
    input  logic                     clk,
    input  logic [$clog2(NREGS)-1:0] ra_a,
    input  logic [$clog2(NREGS)-1:0] ra_b,
    output logic [W-1:0]             rd_a,
    output logic [W-1:0]             rd_b,
    input  logic                     we,
    input  logic [$clog2(NREGS)-1:0] wa,
    input  logic [W-1:0]             wd
);
    localparam int AW = $clog2(NREGS);

    logic [NREGS-1:0][W-1:0] bank;

    for (genvar i = 0; i < NREGS; i++) begin : g_reg
        if (i == 0) begin : g_zero
            assign bank[i] = '0;
        end else begin : g_live
            logic         load;
            logic [W-1:0] q;
            // per-register strobe: decoded destination gated by write enable
            assign load = we && (wa == AW'(i));
            always_ff @(posedge clk) begin
                if (load) begin
                    q <= wd;
                end
            end
            assign bank[i] = q;
        end
    end

    assign rd_a = bank[ra_a];
    assign rd_b = bank[ra_b];

endmodule

// File: rtl/sc_decoder.sv
module sc_decoder
    import sc_core_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output instr_kind_e kind,
    output ctrl_t      ctrl
);
    logic    fn_ok;
    alu_op_e fn_op;

    always_comb begin
        fn_ok = 1'b1;
        fn_op = ALU_ADD;
        unique case (funct)
            FN_ADD:  fn_op = ALU_ADD;
            FN_SUB:  fn_op = ALU_SUB;
            FN_AND:  fn_op = ALU_AND;
            FN_OR:   fn_op = ALU_OR;
            FN_SLT:  fn_op = ALU_SLT;
            default: fn_ok = 1'b0;
        endcase
    end

    // classify the instruction
    always_comb begin
        unique case (opcode)
            OPC_REG:   kind = fn_ok ? KIND_REG_OP : KIND_NOP;
            OPC_LOAD:  kind = KIND_LOAD;
            OPC_STORE: kind = KIND_STORE;
            OPC_BEQ:   kind = KIND_BRANCH;
            OPC_JUMP:  kind = KIND_JUMP;
            default:   kind = KIND_NOP;
        endcase
    end

    // control word per kind
    always_comb begin
        ctrl = '{reg_we: 1'b0, dst_rd: 1'b0, src_imm: 1'b0, wb_mem: 1'b0,
                 mem_we: 1'b0, is_beq: 1'b0, is_jmp: 1'b0, alu_op: ALU_ADD};
        unique case (kind)
            KIND_REG_OP: begin
                ctrl.reg_we = 1'b1;
                ctrl.dst_rd = 1'b1;
                ctrl.alu_op = fn_op;
            end
            KIND_LOAD: begin
                ctrl.reg_we  = 1'b1;
                ctrl.src_imm = 1'b1;
                ctrl.wb_mem  = 1'b1;
            end
            KIND_STORE: begin
                ctrl.src_imm = 1'b1;
                ctrl.mem_we  = 1'b1;
            end
            KIND_BRANCH: begin
                ctrl.is_beq = 1'b1;
                ctrl.alu_op = ALU_SUB;
            end
            KIND_JUMP: begin
                ctrl.is_jmp = 1'b1;
            end
            KIND_NOP: begin
                ctrl.reg_we = 1'b0;
            end
            default: begin
                ctrl.reg_we = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_core_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y,
    output logic         zero
);
    always_comb begin
        unique case (op)
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = '0;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_core_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_PC = '0,
    parameter int              NREGS    = 32
) (
    input  logic            clk,
    input  logic            rst,
    output logic [XLEN-1:0] imem_addr,
    input  logic [XLEN-1:0] imem_data,
    output logic [XLEN-1:0] dmem_addr,
    output logic [XLEN-1:0] dmem_wdata,
    output logic            dmem_we,
    input  logic [XLEN-1:0] dmem_rdata
);
    localparam int RAW = $clog2(NREGS);

    typedef enum logic [1:0] {
        PC_RESET,
        PC_STEP,
        PC_BRANCH,
        PC_JUMP
    } pc_sel_e;

    logic [XLEN-1:0] pc_q;
    logic [XLEN-1:0] pc_d;
    logic [XLEN-1:0] pc_plus4;
    logic [XLEN-1:0] br_tgt;
    logic [XLEN-1:0] jmp_tgt;
    logic [XLEN-1:0] imm_ext;
    pc_sel_e         pc_sel;

    instr_kind_e     kind;
    ctrl_t           ctrl;

    logic [RAW-1:0]  f_rs;
    logic [RAW-1:0]  f_rt;
    logic [RAW-1:0]  f_rd;
    logic [RAW-1:0]  wr_addr;
    logic [XLEN-1:0] rs_val;
    logic [XLEN-1:0] rt_val;
    logic [XLEN-1:0] wr_data;
    logic [XLEN-1:0] alu_b;
    logic [XLEN-1:0] alu_y;
    logic            alu_zero;

    // instruction fields
    assign f_rs    = imem_data[25:21];
    assign f_rt    = imem_data[20:16];
    assign f_rd    = imem_data[15:11];
    assign imm_ext = {{(XLEN-16){imem_data[15]}}, imem_data[15:0]};

    sc_decoder u_dec (
        .opcode (imem_data[31:26]),
        .funct  (imem_data[5:0]),
        .kind   (kind),
        .ctrl   (ctrl)
    );

    assign wr_addr = ctrl.dst_rd ? f_rd : f_rt;
    assign wr_data = ctrl.wb_mem ? dmem_rdata : alu_y;

    sc_regfile #(
        .NREGS (NREGS),
        .W     (XLEN)
    ) u_rf (
        .clk  (clk),
        .ra_a (f_rs),
        .ra_b (f_rt),
        .rd_a (rs_val),
        .rd_b (rt_val),
        .we   (ctrl.reg_we),
        .wa   (wr_addr),
        .wd   (wr_data)
    );

    assign alu_b = ctrl.src_imm ? imm_ext : rt_val;

    sc_alu #(
        .W (XLEN)
    ) u_alu (
        .a    (rs_val),
        .b    (alu_b),
        .op   (ctrl.alu_op),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // data memory side
    assign dmem_addr  = alu_y;
    assign dmem_wdata = rt_val;
    assign dmem_we    = ctrl.mem_we;

    // next-PC candidates
    assign pc_plus4 = pc_q + XLEN'(4);
    assign br_tgt   = pc_plus4 + {imm_ext[XLEN-3:0], 2'b00};
    assign jmp_tgt  = {pc_plus4[XLEN-1:28], imem_data[25:0], 2'b00};

    always_comb begin
        if (rst) begin
            pc_sel = PC_RESET;
        end else if (ctrl.is_jmp) begin
            pc_sel = PC_JUMP;
        end else if (ctrl.is_beq && alu_zero) begin
            pc_sel = PC_BRANCH;
        end else begin
            pc_sel = PC_STEP;
        end
    end

    always_comb begin
        unique case (pc_sel)
            PC_RESET:  pc_d = RESET_PC;
            PC_STEP:   pc_d = pc_plus4;
            PC_BRANCH: pc_d = br_tgt;
            PC_JUMP:   pc_d = jmp_tgt;
            default:   pc_d = pc_plus4;
        endcase
    end

    always_ff @(posedge clk) begin
        pc_q <= pc_d;
    end

    assign imem_addr = pc_q;

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
    import sc_core_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [XLEN-1:0] imem_addr,
    input logic [XLEN-1:0] imem_data,
    input logic            dmem_we,
    input logic [XLEN-1:0] rs_val,
    input logic [XLEN-1:0] rt_val
);
    logic [5:0]      op;
    logic [XLEN-1:0] exp_br;
    logic [XLEN-1:0] exp_jmp;
    logic [XLEN-1:0] exp_seq;
    logic            rst_q = 1'b0;

    assign op      = imem_data[31:26];
    assign exp_seq = imem_addr + 32'd4;
    assign exp_br  = exp_seq + {{14{imem_data[15]}}, imem_data[15:0], 2'b00};
    assign exp_jmp = {exp_seq[31:28], imem_data[25:0], 2'b00};

    always @(posedge clk) begin
        rst_q <= rst;
    end

    // R1: PC is zero in the cycle after a sampled reset
    always @(negedge clk) begin
        if (rst_q) begin
            assert_pc_reset_R1: assert (imem_addr == '0);
        end
    end

    assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
        (op != OPC_BEQ && op != OPC_JUMP) |=> imem_addr == $past(exp_seq));

    assert_store_strobe_R6: assert property (@(posedge clk) disable iff (rst)
        dmem_we == (op == OPC_STORE));

    assert_beq_taken_R7: assert property (@(posedge clk) disable iff (rst)
        (op == OPC_BEQ && rs_val == rt_val) |=> imem_addr == $past(exp_br));

    assert_beq_fall_R8: assert property (@(posedge clk) disable iff (rst)
        (op == OPC_BEQ && rs_val != rt_val) |=> imem_addr == $past(exp_seq));

    assert_jump_R9: assert property (@(posedge clk) disable iff (rst)
        (op == OPC_JUMP) |=> imem_addr == $past(exp_jmp));

    assert_zero_reg_R10: assert property (@(posedge clk) disable iff (rst)
        (imem_data[25:21] == 5'd0) |-> rs_val == '0);

endmodule

bind sc_core sc_core_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .imem_addr (imem_addr),
    .imem_data (imem_data),
    .dmem_we   (dmem_we),
    .rs_val    (rs_val),
    .rt_val    (rt_val)
);

// File: tb/sc_core_tb_top.sv
`timescale 1ns/1ps
module sc_core_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_addr;
    logic [31:0] imem_data;
    logic [31:0] dmem_addr;
    logic [31:0] dmem_wdata;
    logic        dmem_we;
    logic [31:0] dmem_rdata;

    logic [31:0] imem [64];
    logic [31:0] dmem [64];

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;   // 50 MHz

    assign imem_data  = imem[imem_addr[7:2]];
    assign dmem_rdata = dmem[dmem_addr[7:2]];

    always @(posedge clk) begin
        if (dmem_we && !rst) begin
            dmem[dmem_addr[7:2]] <= dmem_wdata;
        end
    end

    sc_core dut_i (
        .clk        (clk),
        .rst        (rst),
        .imem_addr  (imem_addr),
        .imem_data  (imem_data),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we),
        .dmem_rdata (dmem_rdata)
    );

    // encoders
    function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction
    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction
    function automatic logic [31:0] enc_j(input logic [25:0] idx);
        return {6'h02, idx};
    endfunction
    localparam logic [31:0] HALT = {6'h04, 5'd0, 5'd0, 16'hFFFF};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic prep();
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < 64; i++) begin
            imem[i] = 32'h0;
            dmem[i] = 32'h0;
        end
    endtask

    task automatic go();
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        prep();
        imem[0] = HALT;
        go();
        chk("R1 pc after reset", imem_addr, 32'h0);
        chk("R1 no store in reset", {31'd0, dmem_we}, 32'h0);
        // mid-run reset
        imem[0] = 32'h0;
        imem[1] = 32'h0;
        imem[2] = 32'h0;
        imem[3] = HALT;
        run(3);
        chk("R2 sequential pc", imem_addr, 32'd12);
        rst = 1'b1;
        #1;
        chk("R1 pc holds before edge", imem_addr, 32'd12);
        run(1);
        chk("R1 pc cleared at edge", imem_addr, 32'h0);
        rst = 1'b0;
    endtask

    task automatic t_alu(input logic [31:0] a, input logic [31:0] b);
        prep();
        dmem[0] = a;
        dmem[1] = b;
        imem[0]  = enc_i(6'h23, 0, 1, 16'd0);
        imem[1]  = enc_i(6'h23, 0, 2, 16'd4);
        imem[2]  = enc_r(1, 2, 3, 6'h20);
        imem[3]  = enc_r(1, 2, 4, 6'h22);
        imem[4]  = enc_r(1, 2, 5, 6'h24);
        imem[5]  = enc_r(1, 2, 6, 6'h25);
        imem[6]  = enc_r(1, 2, 7, 6'h2A);
        imem[7]  = enc_r(2, 1, 8, 6'h2A);
        imem[8]  = enc_i(6'h2B, 0, 3, 16'd32);
        imem[9]  = enc_i(6'h2B, 0, 4, 16'd36);
        imem[10] = enc_i(6'h2B, 0, 5, 16'd40);
        imem[11] = enc_i(6'h2B, 0, 6, 16'd44);
        imem[12] = enc_i(6'h2B, 0, 7, 16'd48);
        imem[13] = enc_i(6'h2B, 0, 8, 16'd52);
        imem[14] = enc_i(6'h2B, 0, 1, 16'd56);
        imem[15] = HALT;
        go();
        run(20);
        chk("R3 add", dmem[8], a + b);
        chk("R3 sub", dmem[9], a - b);
        chk("R3 and", dmem[10], a & b);
        chk("R3 or", dmem[11], a | b);
        chk("R4 slt rs<rt", dmem[12], ($signed(a) < $signed(b)) ? 32'd1 : 32'd0);
        chk("R4 slt rt<rs", dmem[13], ($signed(b) < $signed(a)) ? 32'd1 : 32'd0);
        chk("R11 source reg kept", dmem[14], a);
        chk("R7 backward self branch", imem_addr, 32'd60);
    endtask

    task automatic t_zero_reg();
        prep();
        dmem[0] = 32'd9;
        dmem[1] = 32'd4;
        dmem[8] = 32'hDEAD_BEEF;
        imem[0] = enc_i(6'h23, 0, 1, 16'd0);
        imem[1] = enc_i(6'h23, 0, 2, 16'd4);
        imem[2] = enc_r(1, 2, 0, 6'h20);
        imem[3] = enc_i(6'h23, 0, 0, 16'd4);
        imem[4] = enc_i(6'h2B, 0, 0, 16'd32);
        imem[5] = enc_i(6'h2B, 0, 2, 16'd36);
        imem[6] = HALT;
        go();
        run(10);
        chk("R10 r0 reads zero", dmem[8], 32'h0);
        chk("R11 r2 untouched", dmem[9], 32'd4);
    endtask

    task automatic t_mem();
        prep();
        dmem[0] = 32'h1234_5678;
        dmem[2] = 32'd40;
        dmem[9] = 32'h0000_CAFE;
        imem[0] = enc_i(6'h23, 0, 9, 16'd8);
        imem[1] = enc_i(6'h23, 0, 10, 16'd0);
        imem[2] = enc_i(6'h2B, 9, 10, 16'hFFF8);   // -8
        imem[3] = enc_i(6'h23, 9, 11, 16'hFFFC);   // -4
        imem[4] = enc_i(6'h2B, 9, 11, 16'd12);
        imem[5] = HALT;
        go();
        chk("R6 no strobe on load", {31'd0, dmem_we}, 32'h0);
        chk("R5 load address", dmem_addr, 32'd8);
        run(2);
        chk("R6 store strobe", {31'd0, dmem_we}, 32'h1);
        chk("R6 store negative offset addr", dmem_addr, 32'd32);
        chk("R6 store data", dmem_wdata, 32'h1234_5678);
        run(8);
        chk("R6 stored word", dmem[8], 32'h1234_5678);
        chk("R5 load negative offset", dmem[13], 32'h0000_CAFE);
    endtask

    task automatic t_branch();
        prep();
        dmem[0] = 32'd5;
        dmem[1] = 32'd5;
        dmem[2] = 32'd7;
        imem[0] = enc_i(6'h23, 0, 1, 16'd0);
        imem[1] = enc_i(6'h23, 0, 2, 16'd4);
        imem[2] = enc_i(6'h23, 0, 3, 16'd8);
        imem[3] = enc_i(6'h04, 1, 2, 16'd1);
        imem[4] = enc_i(6'h2B, 0, 3, 16'd60);
        imem[5] = enc_i(6'h2B, 0, 1, 16'd56);
        imem[6] = enc_i(6'h04, 1, 3, 16'd1);
        imem[7] = enc_i(6'h2B, 0, 3, 16'd52);
        imem[8] = HALT;
        go();
        run(4);
        chk("R7 taken target", imem_addr, 32'd20);
        run(2);
        chk("R8 not taken", imem_addr, 32'd28);
        run(4);
        chk("R7 skipped store", dmem[15], 32'h0);
        chk("R7 landing store", dmem[14], 32'd5);
        chk("R8 fall-through store", dmem[13], 32'd7);
    endtask

    task automatic t_jump();
        prep();
        dmem[0] = 32'd3;
        imem[0]  = enc_i(6'h23, 0, 1, 16'd0);
        imem[1]  = enc_j(26'd10);
        imem[2]  = enc_i(6'h2B, 0, 1, 16'd32);
        imem[10] = enc_i(6'h2B, 0, 1, 16'd36);
        imem[11] = HALT;
        go();
        run(2);
        chk("R9 jump target", imem_addr, 32'd40);
        run(4);
        chk("R9 skipped store", dmem[8], 32'h0);
        chk("R9 target store", dmem[9], 32'd3);
    endtask

    initial begin
        t_reset();
        t_alu(32'd7, 32'd5);
        t_alu(32'hFFFF_FFFD, 32'd2);
        t_alu(32'h8000_0000, 32'h7FFF_FFFF);
        t_alu(32'd5, 32'd5);
        t_zero_reg();
        t_mem();
        t_branch();
        t_jump();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule